// File: doc/BRIEF.md
# Container-Sticky Path Load Balancer

This block spreads packet traffic over a set of egress ports in fixed-size units called containers, not per flow and not per packet. Each packet descriptor brings a flow key and a byte length. The block keeps a running container for every tracked flow and adds the packet's bytes to it. When the packet would push the container past its byte capacity, the block closes that container and opens the next container number for the flow.

The egress port is chosen only when a container opens. The block then takes the least-occupied port that is not marked down. That choice is written into a direct-mapped flow table, and every later packet of the same container reuses the stored port, so packets inside one container never get reordered across paths. A result, made of the container number, the port and two flags, comes out for every accepted packet. It appears a fixed two cycles after the packet is accepted, and the block never waits for later packets.

The flow table is indexed by a fold of the flow key and stores the full key as a tag. A second flow that lands on an occupied row takes the row over and starts again at container 0.

Top module: `cslb_lb`

## Requirements
- R1: A packet presented with `in_valid` high at a rising edge produces exactly one `out_valid` pulse two rising edges later, and results come out in arrival order. `out_valid`, `out_new` and `out_nopath` are low during reset and after it until the first result. `out_nopath` and `out_new` are never high together.
- R2: A packet whose row is empty or holds a different key opens container 0 for its flow: `out_cid` = 0, `out_new` = 1, and the bytes used start at the packet length (even if that length exceeds the capacity).
- R3: If bytes used plus the packet length stays within `CAP_BYTES`, the packet joins the open container. `out_cid` and `out_port` keep the stored values, `out_new` = 0, and the bytes used grow by the length.
- R4: If bytes used plus the length exceeds `CAP_BYTES`, the container closes and the next one opens. `out_cid` is the previous number plus one, wrapping modulo 2^8. `out_new` = 1, the bytes used restart at the packet length, and a fresh port is chosen.
- R5: A port is chosen only when a container opens. The choice is the port with the lowest occupancy among ports not marked down, and on a tie the lowest port index wins. Port i's occupancy is `port_occ[i*OCC_W +: OCC_W]`.
- R6: A port whose bit `port_down[i]` is 1 is never chosen for a new container. If every port is down when a container has to open, the packet comes out with `out_nopath` = 1, `out_new` = 0, `out_cid` = 0 and `out_port` = 0, and the flow's stored state stays as it was.
- R7: A packet that joins an open container uses the stored port, even when occupancies have changed or that port has since been marked down.
- R8: Packets of the same flow presented on consecutive cycles each see the state left by the one before. No result is computed from stale table contents.
- R9: The table row is chosen by folding the key: row bit j is the XOR of all key bits i with i mod `IDX_W` = j. Keys that share a row evict each other, and an evicted flow restarts at container 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Descriptor present this cycle |
| in_key | input | 16 | Flow key |
| in_len | input | 11 | Packet length in bytes |
| port_occ | input | NUM_PORTS*OCC_W | Per-port occupancy, port i in bits i*OCC_W upward |
| port_down | input | NUM_PORTS | Bit i set marks port i unusable for new containers |
| out_valid | output | 1 | Result present |
| out_cid | output | 8 | Container number of the packet |
| out_port | output | $clog2(NUM_PORTS) | Egress port of the packet |
| out_new | output | 1 | Packet opened a container |
| out_nopath | output | 1 | No usable port; packet not placed |

## Verification
Several directed streams are applied, each aimed at one behaviour:
- Three back-to-back packets of one flow, which open, extend and then roll a container. They can only pass if the write-to-read bypass works.
- Equal occupancies, which separate lowest-index tie-breaking from arbitrary selection.
- A lowest-occupancy port that is masked, which must be skipped.
- All ports masked, where the flow's state must be left untouched.
- A follow-on packet whose port has since been masked or become loaded. This separates sticky reuse from per-packet selection.
- Two colliding keys, which expose tag-based eviction.
- A chain of 260 rollovers, which exposes the container-number wrap.

A long random stream then mixes a small key pool, lengths that both fit and overflow, tie-prone occupancies, sparse masks and idle gaps. Every result in it is compared with a reference table kept in the bench.

// File: rtl/cslb_pkg.sv
package cslb_pkg;

    localparam int KEY_W   = 16;
    localparam int LEN_W   = 11;
    localparam int CID_W   = 8;
    localparam int PORT_FW = 8;

    typedef enum logic [1:0] {
        ACT_FRESH  = 2'd0,
        ACT_APPEND = 2'd1,
        ACT_ROLL   = 2'd2,
        ACT_STALL  = 2'd3
    } step_e;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [LEN_W-1:0] len;
    } pkt_t;

    typedef struct packed {
        logic               live;
        logic [KEY_W-1:0]   tag;
        logic [CID_W-1:0]   cid;
        logic [LEN_W-1:0]   used;
        logic [PORT_FW-1:0] port;
    } flow_row_t;

    // Row bit j collects the XOR of key bits whose position mod w equals j.
    function automatic logic [31:0] fold_key(input logic [KEY_W-1:0] k, input int unsigned w);
        logic [31:0] h;
        h = '0;
        for (int i = 0; i < KEY_W; i++) begin
            h[5'(i % w)] = h[5'(i % w)] ^ k[i];
        end
        return h;
    endfunction

endpackage

// File: rtl/cslb_port_pick.sv
module cslb_port_pick #(
    parameter int NUM_PORTS = 4,
    parameter int OCC_W     = 8,
    parameter int PORT_W    = 2
) (
    input  logic [NUM_PORTS*OCC_W-1:0] occ,
    input  logic [NUM_PORTS-1:0]       down,
    output logic                       ok,
    output logic [PORT_W-1:0]          idx
);

    logic [OCC_W-1:0] best_occ;

    // Strict less-than while scanning upward keeps the lowest index on ties.
    always_comb begin
        ok       = 1'b0;
        idx      = '0;
        best_occ = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (!down[i] && (!ok || occ[i*OCC_W +: OCC_W] < best_occ)) begin
                ok       = 1'b1;
                idx      = PORT_W'(i);
                best_occ = occ[i*OCC_W +: OCC_W];
            end
        end
    end

endmodule

// File: rtl/cslb_flow_table.sv
module cslb_flow_table
    import cslb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output flow_row_t        rd_row,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  flow_row_t        wr_row
);

    localparam int DEPTH = 1 << IDX_W;

    flow_row_t rows [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DEPTH; d++) begin
                rows[d].live <= 1'b0;
            end
        end else if (wr_en) begin
            rows[wr_idx] <= wr_row;
        end
    end

    // Registered read; a same-edge write to the same row is forwarded.
    always_ff @(posedge clk) begin
        if (wr_en && wr_idx == rd_idx) begin
            rd_row <= wr_row;
        end else begin
            rd_row <= rows[rd_idx];
        end
    end

endmodule

// File: rtl/cslb_container_step.sv
module cslb_container_step
    import cslb_pkg::*;
#(
    parameter int CAP_BYTES = 1500,
    parameter int PORT_W    = 2
) (
    input  pkt_t              pkt,
    input  flow_row_t         row,
    input  logic              pick_ok,
    input  logic [PORT_W-1:0] pick_idx,
    output step_e             act,
    output flow_row_t         nxt_row
);

    logic             hit;
    logic [LEN_W:0]   sum;
    logic             fits;

    assign hit  = row.live && (row.tag == pkt.key);
    assign sum  = {1'b0, row.used} + {1'b0, pkt.len};
    assign fits = (sum <= (LEN_W+1)'(CAP_BYTES));

    always_comb begin
        nxt_row = row;
        if (hit && fits) begin
            act          = ACT_APPEND;
            nxt_row.used = sum[LEN_W-1:0];
        end else if (!pick_ok) begin
            act = ACT_STALL;
        end else if (!hit) begin
            act          = ACT_FRESH;
            nxt_row.live = 1'b1;
            nxt_row.tag  = pkt.key;
            nxt_row.cid  = '0;
            nxt_row.used = pkt.len;
            nxt_row.port = PORT_FW'(pick_idx);
        end else begin
            act          = ACT_ROLL;
            nxt_row.cid  = row.cid + CID_W'(1);
            nxt_row.used = pkt.len;
            nxt_row.port = PORT_FW'(pick_idx);
        end
    end

endmodule

// File: rtl/cslb_lb.sv
module cslb_lb
    import cslb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int OCC_W     = 8,
    parameter int IDX_W     = 4,
    parameter int CAP_BYTES = 1500,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [KEY_W-1:0]           in_key,
    input  logic [LEN_W-1:0]           in_len,
    input  logic [NUM_PORTS*OCC_W-1:0] port_occ,
    input  logic [NUM_PORTS-1:0]       port_down,
    output logic                       out_valid,
    output logic [CID_W-1:0]           out_cid,
    output logic [PORT_W-1:0]          out_port,
    output logic                       out_new,
    output logic                       out_nopath
);

    // Stage A: capture the descriptor with the congestion view seen beside it.
    logic                       a_valid;
    pkt_t                       a_pkt;
    logic [IDX_W-1:0]           a_idx;
    logic [NUM_PORTS*OCC_W-1:0] a_occ;
    logic [NUM_PORTS-1:0]       a_down;
    logic [IDX_W-1:0]           in_idx;

    assign in_idx = IDX_W'(fold_key(in_key, IDX_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            a_valid <= 1'b0;
        end else begin
            a_valid <= in_valid;
        end
        a_pkt  <= '{key: in_key, len: in_len};
        a_idx  <= in_idx;
        a_occ  <= port_occ;
        a_down <= port_down;
    end

    // Stage B: decide from the looked-up row, write back, register result.
    flow_row_t         cur_row;
    flow_row_t         nxt_row;
    step_e             act;
    logic              pick_ok;
    logic [PORT_W-1:0] pick_idx;
    logic              wr_en;

    assign wr_en = a_valid && (act != ACT_STALL);

    cslb_flow_table #(.IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (in_idx),
        .rd_row (cur_row),
        .wr_en  (wr_en),
        .wr_idx (a_idx),
        .wr_row (nxt_row)
    );

    cslb_port_pick #(
        .NUM_PORTS (NUM_PORTS),
        .OCC_W     (OCC_W),
        .PORT_W    (PORT_W)
    ) u_pick (
        .occ  (a_occ),
        .down (a_down),
        .ok   (pick_ok),
        .idx  (pick_idx)
    );

    cslb_container_step #(
        .CAP_BYTES (CAP_BYTES),
        .PORT_W    (PORT_W)
    ) u_step (
        .pkt      (a_pkt),
        .row      (cur_row),
        .pick_ok  (pick_ok),
        .pick_idx (pick_idx),
        .act      (act),
        .nxt_row  (nxt_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_new    <= 1'b0;
            out_nopath <= 1'b0;
            out_cid    <= '0;
            out_port   <= '0;
        end else begin
            out_valid  <= a_valid;
            out_new    <= a_valid && (act == ACT_FRESH || act == ACT_ROLL);
            out_nopath <= a_valid && (act == ACT_STALL);
            out_cid    <= (act == ACT_STALL) ? '0 : nxt_row.cid;
            out_port   <= (act == ACT_STALL) ? '0 : nxt_row.port[PORT_W-1:0];
        end
    end

endmodule

// File: rtl/cslb_lb_checker.sv
module cslb_lb_checker #(
    parameter int NUM_PORTS = 4,
    parameter int OCC_W     = 8,
    parameter int PORT_W    = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic [NUM_PORTS*OCC_W-1:0] port_occ,
    input logic [NUM_PORTS-1:0]       port_down,
    input logic                       out_valid,
    input logic [PORT_W-1:0]          out_port,
    input logic                       out_new,
    input logic                       out_nopath
);

    logic [NUM_PORTS*OCC_W-1:0] occ_d1, occ_d2;
    logic [NUM_PORTS-1:0]       dn_d1, dn_d2;
    logic                       beaten;
    logic                       chosen_down;

    always_ff @(posedge clk) begin
        occ_d1 <= port_occ;
        occ_d2 <= occ_d1;
        dn_d1  <= port_down;
        dn_d2  <= dn_d1;
    end

    always_comb begin
        beaten = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (!dn_d2[i] && occ_d2[i*OCC_W +: OCC_W] < occ_d2[out_port*OCC_W +: OCC_W]) begin
                beaten = 1'b1;
            end
        end
        chosen_down = dn_d2[out_port];
    end

    a_r1_two_cycle_result: assert property (@(posedge clk) disable iff (rst)
        out_valid == ($past(in_valid, 2) && !$past(rst, 1) && !$past(rst, 2)));

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        out_nopath |-> (out_valid && !out_new));

    a_r5_least_loaded: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_new) |-> !beaten);

    a_r6_never_down: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_new) |-> !chosen_down);

    a_r6_nopath_all_down: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nopath) |-> (&dn_d2));

endmodule

bind cslb_lb cslb_lb_checker #(
    .NUM_PORTS (NUM_PORTS),
    .OCC_W     (OCC_W),
    .PORT_W    (PORT_W)
) u_chk (.*);

// File: tb/cslb_lb_test.sv
`timescale 1ns/1ps
module cslb_lb_test;
    import cslb_pkg::*;

    localparam int NP  = 4;
    localparam int OW  = 8;
    localparam int IW  = 4;
    localparam int CAP = 1500;
    localparam int PW  = 2;
    localparam int QN  = 8192;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [KEY_W-1:0]  in_key = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic [NP*OW-1:0]  port_occ = '0;
    logic [NP-1:0]     port_down = '0;
    logic              out_valid;
    logic [CID_W-1:0]  out_cid;
    logic [PW-1:0]     out_port;
    logic              out_new;
    logic              out_nopath;

    always #4 clk = ~clk;

    cslb_lb #(.NUM_PORTS(NP), .OCC_W(OW), .IDX_W(IW), .CAP_BYTES(CAP)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key), .in_len(in_len),
        .port_occ(port_occ), .port_down(port_down), .out_valid(out_valid),
        .out_cid(out_cid), .out_port(out_port), .out_new(out_new), .out_nopath(out_nopath)
    );

    // Reference flow table
    bit          m_live [1<<IW];
    int          m_tag  [1<<IW];
    int          m_cid  [1<<IW];
    int          m_used [1<<IW];
    int          m_port [1<<IW];

    int    e_cid [QN];
    int    e_port[QN];
    bit    e_new [QN];
    bit    e_np  [QN];
    string e_req [QN];
    int    sent = 0, got = 0, checks = 0, fails = 0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int row_of(input logic [KEY_W-1:0] k);
        int h = 0;
        for (int i = 0; i < KEY_W; i++) if (k[i]) h ^= (1 << (i % IW));
        return h;
    endfunction

    function automatic logic [NP*OW-1:0] occv(input int a, input int b, input int c, input int d);
        return {OW'(d), OW'(c), OW'(b), OW'(a)};
    endfunction

    task automatic model_push(input logic [KEY_W-1:0] k, input int len,
                              input logic [NP*OW-1:0] occ, input logic [NP-1:0] dn, input string lbl);
        int ix = row_of(k);
        bit hit = m_live[ix] && (m_tag[ix] == int'(k));
        int best = -1;
        string tag;
        for (int i = 0; i < NP; i++)
            if (!dn[i] && (best < 0 || occ[i*OW +: OW] < occ[best*OW +: OW])) best = i;
        if (hit && m_used[ix] + len <= CAP) begin
            e_cid[sent] = m_cid[ix]; e_port[sent] = m_port[ix]; e_new[sent] = 0; e_np[sent] = 0;
            m_used[ix] += len; tag = "R3";
        end else if (best < 0) begin
            e_cid[sent] = 0; e_port[sent] = 0; e_new[sent] = 0; e_np[sent] = 1; tag = "R6";
        end else if (!hit) begin
            m_live[ix] = 1; m_tag[ix] = int'(k); m_cid[ix] = 0; m_used[ix] = len; m_port[ix] = best;
            e_cid[sent] = 0; e_port[sent] = best; e_new[sent] = 1; e_np[sent] = 0; tag = "R2";
        end else begin
            m_cid[ix] = (m_cid[ix] + 1) % 256; m_used[ix] = len; m_port[ix] = best;
            e_cid[sent] = m_cid[ix]; e_port[sent] = best; e_new[sent] = 1; e_np[sent] = 0; tag = "R4";
        end
        e_req[sent] = (lbl == "") ? tag : {lbl, "/", tag};
        sent++;
    endtask

    task automatic send(input logic [KEY_W-1:0] k, input int len,
                        input logic [NP*OW-1:0] occ, input logic [NP-1:0] dn, input string lbl);
        @(negedge clk);
        in_valid = 1'b1; in_key = k; in_len = LEN_W'(len); port_occ = occ; port_down = dn;
        model_push(k, len, occ, dn, lbl);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Result monitor, samples away from the rising edge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (got >= sent) begin
                chk(1'b0, "R1", "unexpected result", got, sent);
            end else begin
                chk(out_cid    == CID_W'(e_cid[got]), e_req[got], "cid",    int'(out_cid),  e_cid[got]);
                chk(out_port   == PW'(e_port[got]),   e_req[got], "port",   int'(out_port), e_port[got]);
                chk(out_new    == e_new[got],         e_req[got], "new",    int'(out_new),  int'(e_new[got]));
                chk(out_nopath == e_np[got],          e_req[got], "nopath", int'(out_nopath), int'(e_np[got]));
            end
            got++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog: actual %0d results expected %0d", got, sent);
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: quiet outputs while reset is held
        chk(out_valid == 1'b0 && out_new == 1'b0 && out_nopath == 1'b0, "R1", "reset outputs",
            int'({out_valid, out_new, out_nopath}), 0);
        rst = 1'b0;
        idle(2);
        chk(out_valid == 1'b0, "R1", "idle after reset", int'(out_valid), 0);

        // R8: back-to-back same flow: open, extend, roll
        send(16'h0A05, 700, occv(9, 3, 3, 7), 4'b0000, "R8");
        send(16'h0A05, 700, occv(0, 9, 9, 9), 4'b0000, "R8");
        send(16'h0A05, 700, occv(9, 9, 9, 0), 4'b0000, "R8");
        // R5: tie on equal occupancy picks lowest index
        send(16'h2201, 100, occv(5, 5, 5, 5), 4'b0000, "R5");
        send(16'h3302, 100, occv(8, 2, 2, 6), 4'b0000, "R5");
        // R6: lowest-loaded port masked is skipped
        send(16'h4403, 100, occv(9, 1, 4, 4), 4'b0010, "R6");
        // R7: continuing packet keeps its port although now masked and loaded
        send(16'h4403, 100, occv(0, 0, 255, 0), 4'b0100, "R7");
        idle(1);
        // R6: all ports down leaves state untouched, later fresh open at cid 0
        send(16'h5504, 200, occv(1, 1, 1, 1), 4'b1111, "R6");
        send(16'h5504, 200, occv(3, 2, 1, 0), 4'b0000, "R6");
        send(16'h4403, 1400, occv(1, 1, 1, 1), 4'b1111, "R6");
        send(16'h4403, 100, occv(1, 1, 1, 1), 4'b0000, "R7");
        // R9: keys 0x0001 and 0x0010 share row 1 and evict each other
        send(16'h0001, 300, occv(0, 1, 2, 3), 4'b0000, "R9");
        send(16'h0010, 300, occv(3, 2, 1, 0), 4'b0000, "R9");
        send(16'h0001, 300, occv(3, 0, 1, 2), 4'b0000, "R9");
        // R2: oversize first packet, next packet rolls
        send(16'h6606, 2000, occv(4, 3, 2, 1), 4'b0000, "R2");
        send(16'h6606, 1, occv(1, 2, 3, 4), 4'b0000, "R4");
        // R4: container number wraps after 256 rollovers
        for (int i = 0; i < 260; i++)
            send(16'h7707, 1500, occv(i % 4, (i + 1) % 4, 2, 3), 4'b0000, "R4");
        idle(3);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [KEY_W-1:0] k;
            logic [NP-1:0]    dn;
            int               len;
            k = KEY_W'($urandom_range(0, 23) * 37 + 5);
            len = ($urandom % 4 == 0) ? $urandom_range(900, 2047) : $urandom_range(1, 700);
            for (int b = 0; b < NP; b++) dn[b] = ($urandom % 8 == 0);
            send(k, len, occv($urandom_range(0, 7), $urandom_range(0, 7),
                              $urandom_range(0, 7), $urandom_range(0, 7)), dn, "");
            if ($urandom % 5 == 0) idle(1);
        end
        idle(6);
        // R1: one result per accepted packet
        chk(got == sent, "R1", "result count", got, sent);
        finish_up();
    end

endmodule